// File: doc/BRIEF.md
# TDC Hit Timestamp Encoder

This block sits behind one channel of a tapped-delay-line time-to-digital converter. In every cycle of the channel clock it receives the flip-flop snapshot of the delay line. The snapshot is a thermometer code that the next rising clock edge froze. The block watches for the snapshot to leave the all-zero state, which marks a new hit. It converts the thermometer code into a binary fine time. It attaches a coarse cycle count and an epoch count that extends it, plus a bit that tells whether the measured edge was a leading or a trailing edge. The result is one hit record.

Records go into a small circular store that the reader drains through a first-word-fall-through port. A leading-edge pulse and a trailing-edge pulse from an input stretcher can therefore share one channel, each carrying its own marker. After every accepted hit the channel is blind for a fixed dead time. If the reader falls behind, the oldest record is overwritten and a sticky overflow flag is raised.

The channel controller has two states. ST_ARMED accepts a hit. ST_BLIND counts out the dead time. The transition ST_ARMED→ST_BLIND is taken on an accepted hit. ST_BLIND→ST_ARMED is taken when the dead-time counter expires. ST_ARMED→ST_ARMED and ST_BLIND→ST_BLIND are the idle and counting holds.

Top module: `tdc_hit_encoder`

## Requirements
- R1: While reset is asserted and directly after it, `rec_valid` and `ovf_flag` are 0. The coarse and epoch counters start from zero.
- R2: The fine field equals the number of consecutive ones in `tap_snap` counted upward from bit 0. An all-ones snapshot gives TAPS (16). Record layout: bits [4:0] fine, [8:5] coarse, [12:9] epoch, [13] edge marker.
- R3: Bits above the lowest zero of the snapshot (bubbles) do not affect the fine field. A non-zero snapshot with bit 0 clear yields fine 0.
- R4: A hit is recognised only in a cycle whose snapshot is non-zero while the previous cycle's snapshot was all zeros. A snapshot held non-zero for many cycles gives exactly one record.
- R5: After a hit is accepted in cycle t, new hits in cycles t+1 to t+DEAD_CYC-1 (DEAD_CYC=4) are discarded. A hit in cycle t+DEAD_CYC is accepted.
- R6: The coarse field is the number of clock edges seen since reset release before the hit cycle, modulo 2^COARSE_W (16).
- R7: The epoch counter increments when the coarse counter wraps from all ones to zero. The epoch field holds that edge count divided by 16, modulo 16.
- R8: The edge marker bit of a record equals `trail_edge` in the hit cycle (1 = trailing edge).
- R9: Records are read in arrival order. `rec_valid` is 1 while the store holds a record. `rec_data` shows the oldest one, and `rd_en` with `rec_valid` removes it at the clock edge.
- R10: A hit arriving while the store holds DEPTH (8) records and no read happens overwrites the oldest record. It also sets `ovf_flag`.
- R11: `ovf_flag` stays set until `ovf_clr` is pulsed. If an overwrite and a clear fall in the same cycle, the flag stays set.
- R12: `rd_en` while the store is empty has no effect on contents or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_snap | input | TAPS | Sampled delay-line thermometer snapshot |
| trail_edge | input | 1 | Edge type of the pulse being measured (1 = trailing) |
| rd_en | input | 1 | Remove the oldest record |
| ovf_clr | input | 1 | Clear the overflow flag |
| rec_valid | output | 1 | Store holds at least one record |
| rec_data | output | REC_W | Oldest record |
| ovf_flag | output | 1 | Sticky overwrite indicator |

## Verification
The hardest situation to reach is an overwrite that lands in the same cycle as an overflow clear. It needs a full store, an armed channel and a fresh zero-to-non-zero transition, all aligned on one edge. The bench fills the store with dead-time-spaced hits and raises `ovf_clr` exactly in the hit cycle of the overwriting pulse. A second hard case is a pulse that arrives inside the blind window after a prior zero cycle. The bench places such a pulse two cycles after an accepted hit and a third pulse exactly four cycles after it. Only the first and third may appear in the readout.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_BLIND = 1'b1
    } chan_state_e;

endpackage

// File: rtl/tdc_therm2bin.sv
module tdc_therm2bin #(
    parameter int TAPS = 16,
    parameter int FW   = $clog2(TAPS + 1)
) (
    input  logic [TAPS-1:0] therm,
    output logic [FW-1:0]   fine
);

    // Position of the lowest zero: ones above it are bubbles and are ignored.
    always_comb begin
        fine = FW'(TAPS);
        for (int i = TAPS - 1; i >= 0; i--) begin
            if (!therm[i]) begin
                fine = FW'(i);
            end
        end
    end

endmodule

// File: rtl/tdc_timebase.sv
module tdc_timebase #(
    parameter int COARSE_W = 4,
    parameter int EPOCH_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [COARSE_W-1:0] coarse,
    output logic [EPOCH_W-1:0]  epoch
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse <= '0;
            epoch  <= '0;
        end else begin
            coarse <= coarse + 1'b1;
            if (&coarse) begin
                epoch <= epoch + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdc_ring.sv
module tdc_ring #(
    parameter int W     = 14,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop_req,
    input  logic         clr_ovf,
    output logic [W-1:0] rdata,
    output logic         not_empty,
    output logic         ovf
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          full, pop, drop;

    assign full      = (fill == CW'(DEPTH));
    assign not_empty = (fill != '0);
    assign pop       = pop_req && not_empty;
    assign drop      = push && full && !pop;
    assign rdata     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop || drop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (push && !pop && !drop) begin
                fill <= fill + 1'b1;
            end else if (!push && pop) begin
                fill <= fill - 1'b1;
            end
            if (drop) begin
                ovf <= 1'b1;
            end else if (clr_ovf) begin
                ovf <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tdc_hit_encoder.sv
module tdc_hit_encoder #(
    parameter int TAPS     = 16,
    parameter int COARSE_W = 4,
    parameter int EPOCH_W  = 4,
    parameter int DEPTH    = 8,
    parameter int DEAD_CYC = 4,
    parameter int FW       = $clog2(TAPS + 1),
    parameter int REC_W    = 1 + EPOCH_W + COARSE_W + FW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAPS-1:0]  tap_snap,
    input  logic             trail_edge,
    input  logic             rd_en,
    input  logic             ovf_clr,
    output logic             rec_valid,
    output logic [REC_W-1:0] rec_data,
    output logic             ovf_flag
);

    import tdc_pkg::*;

    localparam int DW = (DEAD_CYC > 2) ? $clog2(DEAD_CYC) : 1;

    chan_state_e          state_q, state_d;
    logic [DW-1:0]        dead_q, dead_d;
    logic                 prev_zero_q;
    logic                 hit_seen, hit_take;
    logic [FW-1:0]        fine;
    logic [COARSE_W-1:0]  coarse;
    logic [EPOCH_W-1:0]   epoch;
    logic [REC_W-1:0]     rec_new;

    tdc_therm2bin #(.TAPS(TAPS), .FW(FW)) u_t2b (
        .therm (tap_snap),
        .fine  (fine)
    );

    tdc_timebase #(.COARSE_W(COARSE_W), .EPOCH_W(EPOCH_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .coarse (coarse),
        .epoch  (epoch)
    );

    // Zero-to-non-zero transition of the snapshot marks a fresh hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_zero_q <= 1'b0;
        end else begin
            prev_zero_q <= (tap_snap == '0);
        end
    end

    assign hit_seen = prev_zero_q && (tap_snap != '0);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            dead_q  <= '0;
        end else begin
            state_q <= state_d;
            dead_q  <= dead_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d  = state_q;
        dead_d   = dead_q;
        hit_take = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (hit_seen) begin
                    hit_take = 1'b1;
                    state_d  = ST_BLIND;
                    dead_d   = DW'(DEAD_CYC - 1);
                end
            end
            ST_BLIND: begin
                if (dead_q <= DW'(1)) begin
                    state_d = ST_ARMED;
                    dead_d  = '0;
                end else begin
                    dead_d  = dead_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_ARMED;
            end
        endcase
    end

    assign rec_new = {trail_edge, epoch, coarse, fine};

    tdc_ring #(.W(REC_W), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (hit_take),
        .wdata     (rec_new),
        .pop_req   (rd_en),
        .clr_ovf   (ovf_clr),
        .rdata     (rec_data),
        .not_empty (rec_valid),
        .ovf       (ovf_flag)
    );

endmodule

// File: rtl/tdc_hit_encoder_chk.sv
module tdc_hit_encoder_chk #(
    parameter int TAPS     = 16,
    parameter int DEAD_CYC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [TAPS-1:0] tap_snap,
    input logic            hit_take,
    input logic            rd_en,
    input logic            ovf_clr,
    input logic            rec_valid,
    input logic            ovf_flag
);

    int   gap;
    logic last_zero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap       <= DEAD_CYC;
            last_zero <= 1'b0;
        end else begin
            last_zero <= (tap_snap == '0);
            if (hit_take) begin
                gap <= 1;
            end else if (gap < DEAD_CYC) begin
                gap <= gap + 1;
            end
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !rec_valid && !ovf_flag); // R1

    AST_FRESH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_take |-> last_zero && (tap_snap != '0)); // R4

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        hit_take |-> gap >= DEAD_CYC); // R5

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_flag && !hit_take |=> !ovf_flag); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag); // R11

    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr && !hit_take |=> !ovf_flag); // R11

    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid && !hit_take |=> !rec_valid); // R12

    AST_READ_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        hit_take |=> rec_valid); // R9

endmodule

bind tdc_hit_encoder tdc_hit_encoder_chk #(.TAPS(TAPS), .DEAD_CYC(DEAD_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_snap  (tap_snap),
    .hit_take  (hit_take),
    .rd_en     (rd_en),
    .ovf_clr   (ovf_clr),
    .rec_valid (rec_valid),
    .ovf_flag  (ovf_flag)
);

// File: tb/tb_tdc_hit_encoder.sv
`timescale 1ns/1ps
module tb_tdc_hit_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int TAPS  = 16;
    localparam int DEPTH = 8;
    localparam int REC_W = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TAPS-1:0]  tap_snap = '0;
    logic             trail_edge = 1'b0;
    logic             rd_en = 1'b0;
    logic             ovf_clr = 1'b0;
    logic             rec_valid;
    logic [REC_W-1:0] rec_data;
    logic             ovf_flag;

    int tests = 0;
    int fails = 0;
    int edges = 0;

    logic [REC_W-1:0] mq [DEPTH];
    int   qh = 0;
    int   qn = 0;
    logic exp_ovf = 1'b0;

    tdc_hit_encoder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tap_snap   (tap_snap),
        .trail_edge (trail_edge),
        .rd_en      (rd_en),
        .ovf_clr    (ovf_clr),
        .rec_valid  (rec_valid),
        .rec_data   (rec_data),
        .ovf_flag   (ovf_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] fine_of(input logic [TAPS-1:0] s);
        for (int i = 0; i < TAPS; i++) if (!s[i]) return 5'(i);
        return 5'(TAPS);
    endfunction

    task automatic expect_push(input logic [TAPS-1:0] s, input logic tr, input logic clr);
        logic [REC_W-1:0] r;
        logic dropped;
        r = {tr, 4'(edges >> 4), 4'(edges), fine_of(s)};
        dropped = 1'b0;
        if (qn == DEPTH) begin
            qh = (qh + 1) % DEPTH;
            qn--;
            dropped = 1'b1;
        end
        mq[(qh + qn) % DEPTH] = r;
        qn++;
        if (dropped) exp_ovf = 1'b1;
        else if (clr) exp_ovf = 1'b0;
    endtask

    // One accepted hit followed by three zero cycles (dead time spacing).
    task automatic hit(input logic [TAPS-1:0] s, input logic tr, input logic clr);
        @(negedge clk);
        tap_snap = s; trail_edge = tr; ovf_clr = clr;
        expect_push(s, tr, clr);
        @(negedge clk);
        tap_snap = '0; ovf_clr = 1'b0;
        chk("R10/R11 ovf_flag", 32'(ovf_flag), 32'(exp_ovf));
        repeat (2) @(negedge clk);
    endtask

    task automatic drain();
        while (qn > 0) begin
            @(negedge clk);
            chk("R9 rec_valid", 32'(rec_valid), 1);
            chk("R2 R6 R7 R8 R9 rec_data", 32'(rec_data), 32'(mq[qh]));
            rd_en = 1'b1;
            qh = (qh + 1) % DEPTH;
            qn--;
        end
        @(negedge clk);
        rd_en = 1'b0;
        chk("R9 empty after drain", 32'(rec_valid), 0);
    endtask

    function automatic logic [TAPS-1:0] pat(input int k);
        logic [TAPS-1:0] p;
        if (k == 0) return 16'h0100;
        if (k >= TAPS) return '1;
        p = (16'h1 << k) - 1'b1;
        if ((k % 2 == 1) && (k <= 13)) p = p | (16'h1 << (k + 2)); // R3 bubble
        return p;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rec_valid in reset", 32'(rec_valid), 0);
        chk("R1 ovf_flag in reset", 32'(ovf_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rec_valid after reset", 32'(rec_valid), 0);

        // R1 R6: first hit timestamp counts from reset release
        hit(16'h0007, 1'b0, 1'b0);
        drain();

        // R2 R3 R8: sweep every fine value in store-sized groups
        for (int g = 0; g < 2; g++) begin
            for (int k = g * 8; k < g * 8 + 8; k++) hit(pat(k), 1'(k), 1'b0);
            drain();
        end

        // R10 R11: fill, overflow, overflow coinciding with clear
        hit(pat(16), 1'b1, 1'b0);
        for (int k = 1; k < 8; k++) hit(pat(k), 1'b0, 1'b0);
        chk("R10 no ovf at exactly full", 32'(ovf_flag), 0);
        hit(pat(9), 1'b1, 1'b0);
        chk("R10 ovf after overwrite", 32'(ovf_flag), 1);
        hit(pat(11), 1'b0, 1'b1);
        chk("R11 set wins over clear", 32'(ovf_flag), 1);
        drain();
        chk("R11 still set after drain", 32'(ovf_flag), 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0; exp_ovf = 1'b0;
        chk("R11 cleared", 32'(ovf_flag), 0);

        // R5: pulse in blind window dropped, pulse at +4 accepted
        @(negedge clk); tap_snap = 16'h001F; trail_edge = 1'b0; expect_push(16'h001F, 1'b0, 1'b0);
        @(negedge clk); tap_snap = '0;
        @(negedge clk); tap_snap = 16'h0003;
        @(negedge clk); tap_snap = '0;
        @(negedge clk); tap_snap = 16'h00FF; trail_edge = 1'b1; expect_push(16'h00FF, 1'b1, 1'b0);
        @(negedge clk); tap_snap = '0;
        repeat (2) @(negedge clk);
        drain();

        // R4: snapshot held non-zero for ten cycles gives one record
        @(negedge clk); tap_snap = 16'h0FFF; trail_edge = 1'b0; expect_push(16'h0FFF, 1'b0, 1'b0);
        repeat (9) @(negedge clk);
        tap_snap = '0;
        repeat (3) @(negedge clk);
        drain();

        // R12: read while empty has no effect
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk("R12 empty read keeps empty", 32'(rec_valid), 0);
        chk("R12 empty read keeps ovf", 32'(ovf_flag), 0);

        // R6 R7: idle stretches move coarse and epoch
        for (int j = 0; j < 5; j++) begin
            repeat (13 + j * 7) @(negedge clk);
            hit(pat(j + 2), 1'(j), 1'b0);
        end
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule